// File: doc/BRIEF.md
# Word-Line Core Array Controller

This block models a linear-select core store together with the sequencer that drives it. Every word has a private full-current read line and a private half-current write line. Every bit position has one shared sense/write line. Driving a word's read line wipes its cores to zero, and each core that was holding a one pulses its bit line. Driving a write line together with a bit line sets the core where the two meet. Either half alone leaves the core as it was.

A requester presents one command per cycle. The command carries a two-bit operation code, a word selection vector and write data. A read selects exactly one word. The controller returns the sensed value one cycle later. In the following cycle it rewrites that value into the same word, because sensing destroyed it. Clear and write take a mask, so any number of words can be wiped, or given the same set bits, in a single cycle. Writes can only turn bits on. To store an exact value, the caller clears the words first.

Top module: `wordline_core_ctrl`

## Requirements
- R1: After reset `busy` and `rd_valid` are 0 and every word reads back as zero.
- R2: An accepted read (`cmd_op` = 1, exactly one bit of `word_sel` set) raises `rd_valid` in the next cycle, for one cycle, with `rd_data` equal to the word's contents before the read.
- R3: A read whose `word_sel` has zero or more than one bit set is dropped: no `rd_valid`, no `busy`, and no word changes.
- R4: After an accepted read, `busy` is 1 for exactly one cycle while the sensed value is written back, so a later read of the same word returns the same value.
- R5: A command presented while `busy` is 1 is ignored and changes no word.
- R6: A clear (`cmd_op` = 2) zeroes every word whose `word_sel` bit is set in the same cycle, leaves other words unchanged, and raises neither `rd_valid` nor `busy`.
- R7: A write (`cmd_op` = 3) ORs `wr_data` into every word whose `word_sel` bit is set, all in one cycle. Bits that are already 1 stay 1, and no bit is ever cleared by a write.
- R8: A clear or write with an all-zero `word_sel` completes without changing any word.
- R9: `cmd_op` = 0 is idle and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 idle, 1 read, 2 clear, 3 write |
| word_sel | input | WORDS | One-hot word for read, word mask for clear and write |
| wr_data | input | BITS | Bits to set on a write |
| busy | output | 1 | Write-back cycle in progress; commands ignored |
| rd_valid | output | 1 | `rd_data` holds the result of last cycle's read |
| rd_data | output | BITS | Sensed word value |

## Verification
The checker takes for granted that `cmd_op` and `word_sel` are stable, known values while `cmd_valid` is high. It assumes nothing else about the requester: a read with a bad selection, or a command issued during write-back, is a legal input that must be dropped. The bench drives every input at the falling clock edge, so each command is settled well before the edge that accepts it. It deliberately issues illegal selections and commands during the busy cycle to show that they are rejected.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_CLEAR = 2'd2,
      OP_WRITE = 2'd3
   } wlc_op_e;
endpackage

// File: rtl/wlc_core_plane.sv
module wlc_core_plane #(
   parameter int WORDS       = 16,
   parameter int BITS        = 16,
   parameter bit RESET_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WORDS-1:0] word_rd,
   input  logic [WORDS-1:0] word_wr,
   input  logic [BITS-1:0]  bit_drv,
   output logic [BITS-1:0]  sense
);
   logic [BITS-1:0] cores [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [BITS-1:0] next_w;
      // full read current wins; half write current sets only where bit line is driven
      always_comb begin
         if (word_rd[w])      next_w = '0;
         else if (word_wr[w]) next_w = cores[w] | bit_drv;
         else                 next_w = cores[w];
      end
      if (RESET_CLEAR) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) cores[w] <= '0;
            else        cores[w] <= next_w;
         end
      end else begin : g_keep
         always_ff @(posedge clk) cores[w] <= next_w;
      end
   end

   // bit line pulses when a core holding one is flipped by its read line
   always_comb begin
      sense = '0;
      for (int w = 0; w < WORDS; w++) begin
         if (word_rd[w]) sense = sense | cores[w];
      end
   end
endmodule

// File: rtl/wlc_cmd_seq.sv
module wlc_cmd_seq
   import wlc_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int BITS  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [WORDS-1:0] word_sel,
   input  logic [BITS-1:0]  wr_data,
   input  logic [BITS-1:0]  sense,
   output logic [WORDS-1:0] word_rd,
   output logic [WORDS-1:0] word_wr,
   output logic [BITS-1:0]  bit_drv,
   output logic             busy,
   output logic             rd_valid,
   output logic [BITS-1:0]  rd_data
);
   wlc_op_e          op;
   logic             accept, sel_single, do_read, do_clear, do_write;
   logic             wb_pend;
   logic [WORDS-1:0] wb_word;
   logic [BITS-1:0]  wb_data;

   assign op         = wlc_op_e'(cmd_op);
   assign accept     = cmd_valid && !wb_pend;
   assign sel_single = (word_sel != '0) && ((word_sel & (word_sel - 1'b1)) == '0);
   assign do_read    = accept && (op == OP_READ) && sel_single;
   assign do_clear   = accept && (op == OP_CLEAR);
   assign do_write   = accept && (op == OP_WRITE);

   always_comb begin
      word_rd = (do_read || do_clear) ? word_sel : '0;
      if (wb_pend) begin
         word_wr = wb_word;
         bit_drv = wb_data;
      end else if (do_write) begin
         word_wr = word_sel;
         bit_drv = wr_data;
      end else begin
         word_wr = '0;
         bit_drv = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_pend  <= 1'b0;
         wb_word  <= '0;
         wb_data  <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         wb_pend  <= do_read;
         rd_valid <= do_read;
         if (do_read) begin
            wb_word <= word_sel;
            wb_data <= sense;
            rd_data <= sense;
         end
      end
   end

   assign busy = wb_pend;
endmodule

// File: rtl/wordline_core_ctrl.sv
module wordline_core_ctrl #(
   parameter int WORDS       = 16,
   parameter int BITS        = 16,
   parameter bit RESET_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [WORDS-1:0] word_sel,
   input  logic [BITS-1:0]  wr_data,
   output logic             busy,
   output logic             rd_valid,
   output logic [BITS-1:0]  rd_data
);
   localparam int PLANE_CORES = WORDS * BITS;

   if (WORDS < 2)          begin : g_bad_words $error("WORDS must be at least 2"); end
   if (BITS < 1)           begin : g_bad_bits  $error("BITS must be at least 1"); end
   if (PLANE_CORES > 4096) begin : g_bad_size  $error("plane too large"); end

   logic [WORDS-1:0] word_rd, word_wr;
   logic [BITS-1:0]  bit_drv, sense;

   wlc_cmd_seq #(.WORDS(WORDS), .BITS(BITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .word_sel(word_sel), .wr_data(wr_data), .sense(sense),
      .word_rd(word_rd), .word_wr(word_wr), .bit_drv(bit_drv),
      .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   wlc_core_plane #(.WORDS(WORDS), .BITS(BITS), .RESET_CLEAR(RESET_CLEAR)) u_plane (
      .clk(clk), .rst_n(rst_n), .word_rd(word_rd), .word_wr(word_wr),
      .bit_drv(bit_drv), .sense(sense)
   );
endmodule

// File: rtl/wlc_ctrl_chk.sv
module wlc_ctrl_chk #(
   parameter int WORDS = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [1:0]       cmd_op,
   input logic [WORDS-1:0] word_sel,
   input logic             busy,
   input logic             rd_valid
);
   logic good_read, bad_read, set_op;
   assign good_read = cmd_valid && !busy && cmd_op == 2'd1 && $onehot(word_sel);
   assign bad_read  = cmd_valid && !busy && cmd_op == 2'd1 && !$onehot(word_sel);
   assign set_op    = cmd_valid && !busy && (cmd_op == 2'd2 || cmd_op == 2'd3);

   a_r2_read_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
      good_read |=> rd_valid);
   a_r2_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(good_read));
   a_r3_bad_sel_silent: assert property (@(posedge clk) disable iff (!rst_n)
      bad_read |=> (!rd_valid && !busy));
   a_r4_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      good_read |=> busy);
   a_r4_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
   a_r5_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rd_valid);
   a_r6_set_ops_silent: assert property (@(posedge clk) disable iff (!rst_n)
      set_op |=> (!rd_valid && !busy));
endmodule

bind wordline_core_ctrl wlc_ctrl_chk #(.WORDS(WORDS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .word_sel(word_sel), .busy(busy), .rd_valid(rd_valid)
);

// File: tb/wordline_core_ctrl_tb_top.sv
module wordline_core_ctrl_tb_top;
   localparam int W = 16;
   localparam int B = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [1:0]   cmd_op = 2'd0;
   logic [W-1:0] word_sel = '0;
   logic [B-1:0] wr_data = '0;
   logic         busy, rd_valid;
   logic [B-1:0] rd_data;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wordline_core_ctrl #(.WORDS(W), .BITS(B)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .word_sel(word_sel), .wr_data(wr_data), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      cmd_valid = 1'b0; cmd_op = 2'd0; word_sel = '0; wr_data = '0;
   endtask

   // read one word, check returned data, busy cycle and write-back completion
   task automatic read_word(input int idx, input logic [B-1:0] exp, input string req);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd1; word_sel = W'(1) << idx;
      @(negedge clk);
      idle();
      check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
      check({req, " rd_data"}, 32'(rd_data), 32'(exp));
      check("R4 busy during write-back", 32'(busy), 32'd1);
      @(negedge clk);
      check("R4 busy single cycle", 32'(busy), 32'd0);
   endtask

   task automatic set_cmd(input logic [1:0] op, input logic [W-1:0] sel,
                          input logic [B-1:0] d, input string req);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; word_sel = sel; wr_data = d;
      @(negedge clk);
      idle();
      check({req, " no rd_valid"}, 32'(rd_valid), 32'd0);
      check({req, " no busy"}, 32'(busy), 32'd0);
   endtask

   task automatic t_reset();
      check("R1 busy after reset", 32'(busy), 32'd0);
      check("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
      for (int i = 0; i < W; i++) read_word(i, '0, "R1 reset word");
   endtask

   task automatic t_write_multi();
      set_cmd(2'd3, 16'h002A, 16'h00F0, "R7 multi write");
      read_word(1, 16'h00F0, "R7 word1");
      read_word(3, 16'h00F0, "R7 word3");
      read_word(5, 16'h00F0, "R7 word5");
      read_word(2, 16'h0000, "R7 unselected word2");
      set_cmd(2'd3, 16'h0008, 16'h0F10, "R7 or write");
      read_word(3, 16'h0FF0, "R7 sets only");
   endtask

   task automatic t_restore();
      read_word(3, 16'h0FF0, "R4 first read");
      read_word(3, 16'h0FF0, "R4 restored");
   endtask

   task automatic t_bad_sel();
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd1; word_sel = 16'h000A;
      @(negedge clk);
      idle();
      check("R3 multi-sel no rd_valid", 32'(rd_valid), 32'd0);
      check("R3 multi-sel no busy", 32'(busy), 32'd0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd1; word_sel = '0;
      @(negedge clk);
      idle();
      check("R3 empty-sel no rd_valid", 32'(rd_valid), 32'd0);
      read_word(1, 16'h00F0, "R3 word1 untouched");
      read_word(3, 16'h0FF0, "R3 word3 untouched");
   endtask

   task automatic t_busy_ignore();
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd1; word_sel = 16'h0020;
      @(negedge clk);
      check("R5 read accepted", 32'(rd_valid), 32'd1);
      cmd_op = 2'd3; word_sel = 16'h0021; wr_data = 16'hFFFF;
      @(negedge clk);
      idle();
      check("R5 no second rd_valid", 32'(rd_valid), 32'd0);
      read_word(5, 16'h00F0, "R5 word5 unchanged");
      read_word(0, 16'h0000, "R5 word0 unchanged");
   endtask

   task automatic t_clear();
      set_cmd(2'd2, 16'h000A, 16'hFFFF, "R6 clear");
      read_word(1, 16'h0000, "R6 word1 cleared");
      read_word(3, 16'h0000, "R6 word3 cleared");
      read_word(5, 16'h00F0, "R6 word5 kept");
   endtask

   task automatic t_empty_and_idle();
      set_cmd(2'd3, '0, 16'hFFFF, "R8 empty write");
      set_cmd(2'd2, '0, 16'h0000, "R8 empty clear");
      set_cmd(2'd0, 16'hFFFF, 16'hFFFF, "R9 idle op");
      read_word(5, 16'h00F0, "R8 word5 after empty masks");
      read_word(7, 16'h0000, "R9 word7 after idle");
   endtask

   task automatic t_full_mask();
      set_cmd(2'd3, '1, 16'hA5A5, "R7 all words");
      read_word(0, 16'hA5A5, "R7 word0 all-mask");
      read_word(5, 16'hA5F5, "R7 word5 all-mask");
      read_word(W - 1, 16'hA5A5, "R7 top word all-mask");
      set_cmd(2'd2, '1, '0, "R6 clear all");
      read_word(0, 16'h0000, "R6 word0 all cleared");
      read_word(W - 1, 16'h0000, "R6 top word all cleared");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_multi();
      t_restore();
      t_bad_sel();
      t_busy_ignore();
      t_clear();
      t_empty_and_idle();
      t_full_mask();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule